// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken. Two predictors run side by side. The first is a table of 2-bit saturating counters indexed by the branch address. The second is a table of the same kind indexed by the branch address XORed with a register of recent global outcomes. A third table of 2-bit counters, indexed by the branch address, learns for each branch which of the two predictors is more reliable. A lookup is purely combinational: the fetch stage presents a PC and reads the final prediction in the same cycle. It also reads both component predictions, both table indices and the current history. The pipeline carries these values with the branch.

When the branch resolves, the core returns the carried values together with the real outcome on the update port. The update trains both direction tables and the chooser, shifts the outcome into the global history, and counts the misprediction. If the final prediction was wrong, the history is rebuilt from the copy that was carried with the branch, so outcomes recorded after that point are discarded. Two saturating counters track lookups and mispredictions, so that accuracy can be compared with a static always-taken policy.

Top module: `tournament_bp`

## Requirements
- R1: After reset every counter in all three tables holds 01 (weakly not-taken), the history is zero and both event counts are zero, so any first lookup predicts not-taken and uses the address-indexed predictor.
- R2: A direction counter predicts taken exactly when its value is 2 or 3 (MSB set). An update with taken increments it and an update with not-taken decrements it, and it saturates at 3 and at 0.
- R3: A counter at 3 that receives a single not-taken outcome still predicts taken on the next lookup.
- R4: The address-indexed table and the chooser use lk_pc[IDX_W+1:2] as index. The two lowest PC bits have no effect on any lookup output except through the upper bits.
- R5: The history-indexed table uses the address index XOR the folded history. The folded history is the XOR of the history split into IDX_W-bit chunks, where chunk c is bits [c*IDX_W +: IDX_W] and bits above HIST_W read as zero.
- R6: Each update shifts the outcome into history bit 0. The older bits come from the current history when up_final_pred equals up_taken, and from up_hist otherwise. The history does not change without an update.
- R7: A chooser entry trains only when up_local_pred differs from up_gshare_pred. It increments when the history-indexed prediction matched the outcome and decrements otherwise. Chooser MSB 1 selects the history-indexed prediction.
- R8: lk_taken equals the component prediction selected by the chooser entry of the looked-up address, in the same cycle as lk_pc. Lookups alone change no table or history.
- R9: lookup_count increments on each cycle with lk_valid. mispredict_count increments on each update whose up_final_pred differs from up_taken. Both saturate at all-ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | A lookup is made this cycle (counted) |
| lk_pc | input | PC_W | Branch address for the lookup |
| lk_taken | output | 1 | Final direction prediction |
| lk_local_pred | output | 1 | Address-indexed component prediction |
| lk_gshare_pred | output | 1 | History-indexed component prediction |
| lk_local_idx | output | IDX_W | Address index (also chooser index) |
| lk_gshare_idx | output | IDX_W | History-XOR index |
| lk_hist | output | HIST_W | Current global history snapshot |
| up_valid | input | 1 | A resolved branch is reported this cycle |
| up_taken | input | 1 | Resolved outcome |
| up_local_idx | input | IDX_W | Address index carried from lookup |
| up_gshare_idx | input | IDX_W | History-XOR index carried from lookup |
| up_local_pred | input | 1 | Address-indexed prediction carried from lookup |
| up_gshare_pred | input | 1 | History-indexed prediction carried from lookup |
| up_final_pred | input | 1 | Final prediction carried from lookup |
| up_hist | input | HIST_W | History snapshot carried from lookup |
| lookup_count | output | CNT_W | Saturating lookup count |
| mispredict_count | output | CNT_W | Saturating misprediction count |

## Verification
The hardest case to reach from the ports is a chooser that has moved to the history-indexed side while the two components disagree at the looked-up address. A second hard case is a history restore whose carried snapshot differs from the live history. For the first, the bench issues updates with chosen indices and component predictions. It computes ahead of time the history that those updates will leave behind, so that the trained history-indexed entry is exactly the one the final lookup selects. For the second, the bench issues two lookups before either update, so that the second update carries a stale snapshot, and it also forces a restore with a distinctive bit pattern.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_RESET = 2'b01;

    localparam int TBL_LOC = 0;
    localparam int TBL_GSH = 1;
    localparam int TBL_CHO = 2;
    localparam int N_TBL   = 3;

    // Saturating 2-bit step toward taken (up=1) or not-taken (up=0).
    function automatic ctr_t ctr_train(input ctr_t c, input logic up);
        ctr_t r;
        if (up) r = (c == 2'b11) ? c : c + 2'b01;
        else    r = (c == 2'b00) ? c : c - 2'b01;
        return r;
    endfunction

endpackage

// File: rtl/bp_counter_table.sv
`timescale 1ns/1ps
module bp_counter_table
    import bp_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);

    localparam int DEPTH = 1 << IDX_W;

    ctr_t tbl_q [DEPTH];
    ctr_t tbl_d [DEPTH];

    assign rd_taken = tbl_q[rd_idx][1];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = ctr_train(tbl_q[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= CTR_RESET;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

endmodule

// File: rtl/bp_history.sv
`timescale 1ns/1ps
module bp_history #(
    parameter int HIST_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              restore,
    input  logic [HIST_W-1:0] restore_val,
    input  logic              outcome,
    output logic [HIST_W-1:0] hist
);

    logic [HIST_W-1:0] hist_d, hist_q;
    logic [HIST_W-1:0] base;

    assign hist = hist_q;

    always_comb begin
        base   = restore ? restore_val : hist_q;
        hist_d = hist_q;
        if (upd_en) begin
            hist_d = (base << 1) | HIST_W'(outcome);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

endmodule

// File: rtl/bp_perf_counters.sv
`timescale 1ns/1ps
module bp_perf_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_inc,
    input  logic             mis_inc,
    output logic [CNT_W-1:0] lk_cnt,
    output logic [CNT_W-1:0] mis_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] lk;
        logic [CNT_W-1:0] mis;
    } perf_t;

    perf_t perf_d, perf_q;

    assign lk_cnt  = perf_q.lk;
    assign mis_cnt = perf_q.mis;

    always_comb begin
        perf_d = perf_q;
        if (lk_inc && perf_q.lk != CNT_MAX)   perf_d.lk  = perf_q.lk + 1'b1;
        if (mis_inc && perf_q.mis != CNT_MAX) perf_d.mis = perf_q.mis + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) perf_q <= '0;
        else        perf_q <= perf_d;
    end

endmodule

// File: rtl/tournament_bp.sv
`timescale 1ns/1ps
module tournament_bp
    import bp_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int IDX_W  = 10,
    parameter int HIST_W = 12,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic              lk_local_pred,
    output logic              lk_gshare_pred,
    output logic [IDX_W-1:0]  lk_local_idx,
    output logic [IDX_W-1:0]  lk_gshare_idx,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic              up_taken,
    input  logic [IDX_W-1:0]  up_local_idx,
    input  logic [IDX_W-1:0]  up_gshare_idx,
    input  logic              up_local_pred,
    input  logic              up_gshare_pred,
    input  logic              up_final_pred,
    input  logic [HIST_W-1:0] up_hist,
    output logic [CNT_W-1:0]  lookup_count,
    output logic [CNT_W-1:0]  mispredict_count
);

    // History is folded into IDX_W-bit chunks before the XOR.
    localparam int N_CHUNK = (HIST_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W   = N_CHUNK * IDX_W;

    logic [HIST_W-1:0] hist_q;
    logic [PAD_W-1:0]  hist_pad;
    logic [IDX_W-1:0]  hist_fold;
    logic [IDX_W-1:0]  pc_idx;
    logic              up_mispredict;
    logic              unused_pc_bits;

    logic [N_TBL-1:0][IDX_W-1:0] tbl_rd_idx;
    logic [N_TBL-1:0][IDX_W-1:0] tbl_wr_idx;
    logic [N_TBL-1:0]            tbl_wr_en;
    logic [N_TBL-1:0]            tbl_wr_up;
    logic [N_TBL-1:0]            tbl_rd_taken;

    assign pc_idx         = lk_pc[IDX_W+1:2];
    assign unused_pc_bits = ^{lk_pc[PC_W-1:IDX_W+2], lk_pc[1:0]};

    always_comb begin
        hist_pad               = '0;
        hist_pad[HIST_W-1:0]   = hist_q;
        hist_fold              = '0;
        for (int c = 0; c < N_CHUNK; c++) begin
            hist_fold = hist_fold ^ hist_pad[c*IDX_W +: IDX_W];
        end
    end

    // Read side of the three tables.
    always_comb begin
        tbl_rd_idx[TBL_LOC] = pc_idx;
        tbl_rd_idx[TBL_GSH] = pc_idx ^ hist_fold;
        tbl_rd_idx[TBL_CHO] = pc_idx;
    end

    // Write side: direction tables always train; chooser only on disagreement.
    always_comb begin
        up_mispredict       = up_final_pred != up_taken;
        tbl_wr_en[TBL_LOC]  = up_valid;
        tbl_wr_idx[TBL_LOC] = up_local_idx;
        tbl_wr_up[TBL_LOC]  = up_taken;
        tbl_wr_en[TBL_GSH]  = up_valid;
        tbl_wr_idx[TBL_GSH] = up_gshare_idx;
        tbl_wr_up[TBL_GSH]  = up_taken;
        tbl_wr_en[TBL_CHO]  = up_valid && (up_local_pred != up_gshare_pred);
        tbl_wr_idx[TBL_CHO] = up_local_idx;
        tbl_wr_up[TBL_CHO]  = (up_gshare_pred == up_taken);
    end

    for (genvar t = 0; t < N_TBL; t++) begin : g_tbl
        bp_counter_table #(
            .IDX_W (IDX_W)
        ) tbl_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (tbl_rd_idx[t]),
            .rd_taken (tbl_rd_taken[t]),
            .wr_en    (tbl_wr_en[t]),
            .wr_idx   (tbl_wr_idx[t]),
            .wr_up    (tbl_wr_up[t])
        );
    end

    bp_history #(
        .HIST_W (HIST_W)
    ) hist_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .upd_en      (up_valid),
        .restore     (up_mispredict),
        .restore_val (up_hist),
        .outcome     (up_taken),
        .hist        (hist_q)
    );

    bp_perf_counters #(
        .CNT_W (CNT_W)
    ) perf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lk_inc  (lk_valid),
        .mis_inc (up_valid && up_mispredict),
        .lk_cnt  (lookup_count),
        .mis_cnt (mispredict_count)
    );

    assign lk_local_pred  = tbl_rd_taken[TBL_LOC];
    assign lk_gshare_pred = tbl_rd_taken[TBL_GSH];
    assign lk_taken       = tbl_rd_taken[TBL_CHO] ? tbl_rd_taken[TBL_GSH]
                                                  : tbl_rd_taken[TBL_LOC];
    assign lk_local_idx   = tbl_rd_idx[TBL_LOC];
    assign lk_gshare_idx  = tbl_rd_idx[TBL_GSH];
    assign lk_hist        = hist_q;

endmodule

// File: rtl/tournament_bp_checker.sv
`timescale 1ns/1ps
module tournament_bp_checker #(
    parameter int HIST_W = 12,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lk_valid,
    input logic              lk_taken,
    input logic              lk_local_pred,
    input logic              lk_gshare_pred,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic              up_taken,
    input logic              up_final_pred,
    input logic [HIST_W-1:0] up_hist,
    input logic [CNT_W-1:0]  lookup_count,
    input logic [CNT_W-1:0]  mispredict_count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    p_hist_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
        up_valid |=> lk_hist[0] == $past(up_taken));

    p_hist_restore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_final_pred != up_taken)
        |=> lk_hist[HIST_W-1:1] == $past(up_hist[HIST_W-2:0]));

    p_hist_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !up_valid |=> $stable(lk_hist));

    p_lookup_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && lookup_count != CNT_MAX)
        |=> lookup_count == CNT_W'($past(lookup_count) + 1'b1));

    p_lookup_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lookup_count == CNT_MAX |=> lookup_count == CNT_MAX);

    p_mis_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(up_valid && up_final_pred != up_taken) |=> $stable(mispredict_count));

    p_agree_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_local_pred == lk_gshare_pred) |-> lk_taken == lk_local_pred);

endmodule

bind tournament_bp tournament_bp_checker #(
    .HIST_W (HIST_W),
    .CNT_W  (CNT_W)
) chk_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .lk_valid         (lk_valid),
    .lk_taken         (lk_taken),
    .lk_local_pred    (lk_local_pred),
    .lk_gshare_pred   (lk_gshare_pred),
    .lk_hist          (lk_hist),
    .up_valid         (up_valid),
    .up_taken         (up_taken),
    .up_final_pred    (up_final_pred),
    .up_hist          (up_hist),
    .lookup_count     (lookup_count),
    .mispredict_count (mispredict_count)
);

// File: tb/tournament_bp_tb_top.sv
`timescale 1ns/1ps
module tournament_bp_tb_top;

    localparam int PC_W   = 16;
    localparam int IDX_W  = 4;
    localparam int HIST_W = 6;
    localparam int CNT_W  = 4;
    localparam int ENT    = 1 << IDX_W;
    localparam int CMAX   = (1 << CNT_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lk_valid = 1'b0;
    logic [PC_W-1:0]   lk_pc = '0;
    logic              lk_taken, lk_local_pred, lk_gshare_pred;
    logic [IDX_W-1:0]  lk_local_idx, lk_gshare_idx;
    logic [HIST_W-1:0] lk_hist;
    logic              up_valid = 1'b0;
    logic              up_taken = 1'b0;
    logic [IDX_W-1:0]  up_local_idx = '0;
    logic [IDX_W-1:0]  up_gshare_idx = '0;
    logic              up_local_pred = 1'b0;
    logic              up_gshare_pred = 1'b0;
    logic              up_final_pred = 1'b0;
    logic [HIST_W-1:0] up_hist = '0;
    logic [CNT_W-1:0]  lookup_count, mispredict_count;

    always #4 clk = ~clk;

    tournament_bp #(
        .PC_W (PC_W), .IDX_W (IDX_W), .HIST_W (HIST_W), .CNT_W (CNT_W)
    ) dut_i (
        .clk (clk), .rst_n (rst_n),
        .lk_valid (lk_valid), .lk_pc (lk_pc), .lk_taken (lk_taken),
        .lk_local_pred (lk_local_pred), .lk_gshare_pred (lk_gshare_pred),
        .lk_local_idx (lk_local_idx), .lk_gshare_idx (lk_gshare_idx),
        .lk_hist (lk_hist),
        .up_valid (up_valid), .up_taken (up_taken),
        .up_local_idx (up_local_idx), .up_gshare_idx (up_gshare_idx),
        .up_local_pred (up_local_pred), .up_gshare_pred (up_gshare_pred),
        .up_final_pred (up_final_pred), .up_hist (up_hist),
        .lookup_count (lookup_count), .mispredict_count (mispredict_count)
    );

    // Reference state built from the requirements.
    int          m_loc [ENT];
    int          m_gsh [ENT];
    int          m_cho [ENT];
    logic [5:0]  m_hist;
    int          m_lk, m_mis;
    int          n_chk = 0, n_fail = 0;
    bit          done = 1'b0;

    int          cap_li [2], cap_gi [2];
    bit          cap_lp [2], cap_gp [2], cap_fp [2];
    logic [5:0]  cap_h  [2];

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int fold(input logic [5:0] h);
        return int'(h[3:0] ^ {2'b00, h[5:4]});
    endfunction

    function automatic int train(input int c, input bit up);
        if (up) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic do_lookup(input logic [PC_W-1:0] pc, input int slot);
        int li, gi;
        bit el, eg, et;
        @(negedge clk);
        lk_valid = 1'b1; lk_pc = pc; up_valid = 1'b0;
        #1;
        li = int'(pc[5:2]);
        gi = li ^ fold(m_hist);
        el = m_loc[li] >= 2;
        eg = m_gsh[gi] >= 2;
        et = (m_cho[li] >= 2) ? eg : el;
        chk("R4", int'(lk_local_idx), li);
        chk("R5", int'(lk_gshare_idx), gi);
        chk("R2", int'(lk_local_pred), int'(el));
        chk("R5", int'(lk_gshare_pred), int'(eg));
        chk("R8", int'(lk_taken), int'(et));
        chk("R6", int'(lk_hist), int'(m_hist));
        chk("R9", int'(lookup_count), m_lk);
        chk("R9", int'(mispredict_count), m_mis);
        cap_li[slot] = li; cap_gi[slot] = gi;
        cap_lp[slot] = el; cap_gp[slot] = eg; cap_fp[slot] = et;
        cap_h[slot]  = m_hist;
        @(posedge clk);
        if (m_lk < CMAX) m_lk++;
    endtask

    task automatic do_raw(input int li, input int gi, input bit lp, input bit gp,
                          input bit fp, input logic [5:0] h, input bit taken);
        logic [5:0] base;
        @(negedge clk);
        lk_valid = 1'b0; up_valid = 1'b1;
        up_local_idx = IDX_W'(li); up_gshare_idx = IDX_W'(gi);
        up_local_pred = lp; up_gshare_pred = gp; up_final_pred = fp;
        up_hist = h; up_taken = taken;
        @(posedge clk);
        m_loc[li] = train(m_loc[li], taken);
        m_gsh[gi] = train(m_gsh[gi], taken);
        if (lp != gp) m_cho[li] = train(m_cho[li], gp == taken);
        base   = (fp != taken) ? h : m_hist;
        m_hist = {base[4:0], taken};
        if (fp != taken && m_mis < CMAX) m_mis++;
    endtask

    task automatic do_update(input int slot, input bit taken);
        do_raw(cap_li[slot], cap_gi[slot], cap_lp[slot], cap_gp[slot],
               cap_fp[slot], cap_h[slot], taken);
    endtask

    task automatic lu(input logic [PC_W-1:0] pc, input bit taken);
        do_lookup(pc, 0);
        do_update(0, taken);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        logic [5:0]  h_fut;
        int          g, g2;
        for (int i = 0; i < ENT; i++) begin
            m_loc[i] = 1; m_gsh[i] = 1; m_cho[i] = 1;
        end
        m_hist = '0; m_lk = 0; m_mis = 0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen at the ports.
        lk_pc = 16'h0024;
        #1;
        chk("R1", int'(lk_taken), 0);
        chk("R1", int'(lk_local_pred), 0);
        chk("R1", int'(lk_gshare_pred), 0);
        chk("R1", int'(lk_hist), 0);
        chk("R1", int'(lookup_count), 0);
        chk("R1", int'(mispredict_count), 0);

        // R4: byte-offset bits do not move the index.
        do_lookup(16'h0043, 0);
        chk("R4", int'(lk_local_idx), 0);
        do_lookup(16'h0047, 0);
        chk("R4", int'(lk_local_idx), 1);

        // R3: strongly taken survives one not-taken.
        lu(16'h0008, 1'b1); lu(16'h0008, 1'b1); lu(16'h0008, 1'b1);
        lu(16'h0008, 1'b0);
        do_lookup(16'h0008, 0);
        chk("R3", int'(lk_local_pred), 1);

        // R2: saturation at the bottom and one-step hysteresis upward.
        lu(16'h0008, 1'b0); lu(16'h0008, 1'b0); lu(16'h0008, 1'b0);
        do_lookup(16'h0008, 0);
        chk("R2", int'(lk_local_pred), 0);
        lu(16'h0008, 1'b1);
        do_lookup(16'h0008, 0);
        chk("R2", int'(lk_local_pred), 0);

        // R6: restore from carried snapshot on mispredict, live history otherwise.
        do_lookup(16'h0010, 0);
        do_raw(cap_li[0], cap_gi[0], cap_lp[0], cap_gp[0], 1'b0, 6'b101010, 1'b1);
        do_lookup(16'h0010, 0);
        chk("R6", int'(lk_hist), 6'b010101);
        do_raw(cap_li[0], cap_gi[0], cap_lp[0], cap_gp[0], 1'b0, 6'b111111, 1'b0);
        do_lookup(16'h0010, 0);
        chk("R6", int'(lk_hist), 6'b101010);

        // R7: chooser flips index 15 to the history side; components disagree.
        h_fut = {m_hist[1:0], 4'b1100};
        g  = 15 ^ fold(h_fut);
        g2 = g ^ 1;
        do_raw(14, g, 1'b1, 1'b1, 1'b1, m_hist, 1'b1);
        do_raw(14, g, 1'b1, 1'b1, 1'b1, m_hist, 1'b1);
        do_raw(15, g2, 1'b1, 1'b0, 1'b0, m_hist, 1'b0);
        do_raw(15, g2, 1'b1, 1'b0, 1'b0, m_hist, 1'b0);
        do_lookup(16'h003C, 0);
        chk("R7", int'(lk_gshare_idx), g);
        chk("R7", int'(lk_local_pred), 0);
        chk("R7", int'(lk_gshare_pred), 1);
        chk("R7", int'(lk_taken), 1);

        // Sweep: pairs of lookups ahead of their updates (stale snapshots).
        lfsr = 16'hACE1;
        for (int it = 0; it < 800; it++) begin
            logic [PC_W-1:0] pa, pb;
            bit ta, tb;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            pa = {8'h00, lfsr[7:0]};
            pb = {8'h00, lfsr[15:8]};
            ta = pa[3] ? (lfsr[11:9] != 3'd0) : (lfsr[11:9] == 3'd0);
            tb = pb[4] ? (lfsr[3:1] != 3'd0) : (lfsr[3:1] == 3'd0);
            do_lookup(pa, 0);
            do_lookup(pb, 1);
            do_update(0, ta);
            do_update(1, tb);
        end

        // R9: both counts are saturated after the sweep.
        do_lookup(16'h0000, 0);
        chk("R9", int'(lookup_count), CMAX);
        chk("R9", int'(mispredict_count), CMAX);

        @(negedge clk);
        lk_valid = 1'b0; up_valid = 1'b0;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule